// File: doc/BRIEF.md
# Nibble-Decomposed 8x8 Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product with no clock and no state. Each operand is cut into a low and a high 4-bit half. Four small array multipliers form the four cross products of those halves. Every array is built from AND gates feeding rows of full adders.

The cross products overlap in the middle two nibble columns of the result. Each overlapping column is summed by a three-operand adder. A single row of full adders reduces three nibbles to a sum vector and a carry vector. A ripple carry-propagate adder then adds the carry vector one place up.

The carry leaving the lower overlapping column can be worth 0, 1 or 2. It is passed upward as two weight-one signals. One fills the otherwise idle lowest slot of the shifted carry vector. The other enters the carry input of the propagate adder. The top nibble is the high half of the high-by-high product plus the carry from the column below.

Top module: `nibble_mult8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals `op_a` times `op_b` as a 16-bit unsigned number.
- R2: Each 4x4 cross product is exact; for example, operands 0x0D and 0x0B give 0x008F (143).
- R3: `prod[3:0]` always equals the low nibble of the low-half-by-low-half product.
- R4: The carry out of the column holding `prod[7:4]` may take the value 2. It still reaches the column holding `prod[11:8]` with its full weight, so operand pairs whose three middle-column nibbles sum to 32 or more produce the correct product.
- R5: The largest operands, 0xFF times 0xFF, give 0xFE01, and the top-nibble addition never overflows past bit 15.
- R6: A zero on either operand gives a zero product.
- R7: An operand of 1 returns the other operand, zero-extended to 16 bits.
- R8: The output is purely combinational: a new operand pair shows at `prod` within the same clock period it is applied, with no clock or reset input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product of op_a and op_b |

## Verification
A fault in one cross-product array corrupts only the operand pairs whose halves reach the broken cell. Because the block has no state, the fault appears at `prod` in the same cycle as the first such pair. A broken weight-two carry shows up only in the upper eight bits, and only for pairs where the middle column overflows twice. For this reason the full operand space is swept rather than sampled. The bench also counts the double-carry pairs it meets.

// File: rtl/mul_nib_pkg.sv
package mul_nib_pkg;
    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic [NIB_W-1:0] n3;
        logic [NIB_W-1:0] n2;
        logic [NIB_W-1:0] n1;
        logic [NIB_W-1:0] n0;
    } prod_nibbles_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    assign s_o  = x_i ^ y_i ^ ci_i;
    assign co_o = (x_i & y_i) | (ci_i & (x_i ^ y_i));
endmodule

// File: rtl/cpa_ripple.sv
module cpa_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W:0]   sum_o
);
    logic [W:0] chain;
    assign chain[0] = ci_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_cell u_fa (
            .x_i (x_i[i]),
            .y_i (y_i[i]),
            .ci_i(chain[i]),
            .s_o (sum_o[i]),
            .co_o(chain[i+1])
        );
    end

    assign sum_o[W] = chain[W];
endmodule

// File: rtl/nib_array_mul.sv
module nib_array_mul #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] prod_o
);
    for (genvar j = 0; j < W; j++) begin : g_row
        logic [W-1:0] pp;
        logic [W-1:0] s;
        logic         co;

        assign pp = x_i & {W{y_i[j]}};

        if (j == 0) begin : g_first
            assign s  = pp;
            assign co = 1'b0;
        end else begin : g_next
            logic [W-1:0] upper;
            logic [W:0]   c;
            assign upper = {g_row[j-1].co, g_row[j-1].s[W-1:1]};
            assign c[0]  = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_cell
                fa_cell u_fa (
                    .x_i (upper[i]),
                    .y_i (pp[i]),
                    .ci_i(c[i]),
                    .s_o (s[i]),
                    .co_o(c[i+1])
                );
            end
            assign co = c[W];
        end

        assign prod_o[j] = s[0];
    end

    assign prod_o[2*W-1:W] = {g_row[W-1].co, g_row[W-1].s[W-1:1]};

    // R2
    always_comb begin
        if (!$isunknown({x_i, y_i})) begin
            nib_prod_chk: assert (prod_o == (2*W)'(x_i) * (2*W)'(y_i))
                else $error("nibble array product wrong");
        end
    end
endmodule

// File: rtl/add3_csa.sv
module add3_csa #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    input  logic         slot_i,
    input  logic         ci_i,
    output logic [W+1:0] res_o
);
    logic [W-1:0] sv;
    logic [W-1:0] cv;

    for (genvar i = 0; i < W; i++) begin : g_csa
        fa_cell u_fa (
            .x_i (x_i[i]),
            .y_i (y_i[i]),
            .ci_i(z_i[i]),
            .s_o (sv[i]),
            .co_o(cv[i])
        );
    end

    cpa_ripple #(.W(W+1)) u_cpa (
        .x_i  ({1'b0, sv}),
        .y_i  ({cv, slot_i}),
        .ci_i (ci_i),
        .sum_o(res_o)
    );

    // R4
    always_comb begin
        if (!$isunknown({x_i, y_i, z_i, slot_i, ci_i})) begin
            add3_sum_chk: assert (32'(res_o) == 32'(x_i) + 32'(y_i) + 32'(z_i)
                                  + 32'(slot_i) + 32'(ci_i))
                else $error("three-operand sum wrong");
        end
    end
endmodule

// File: rtl/nibble_mult8.sv
module nibble_mult8 #(
    parameter int unsigned HALF_W = mul_nib_pkg::NIB_W
) (
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    output logic [4*HALF_W-1:0] prod
);
    import mul_nib_pkg::*;

    localparam int unsigned PP_W  = 2 * HALF_W;
    localparam int unsigned COL_W = HALF_W + 2;

    logic [PP_W-1:0]  pp_ll, pp_hl, pp_lh, pp_hh;
    logic [COL_W-1:0] mid_col, hi_col;
    logic [HALF_W:0]  top_col;
    logic             mid_c_slot, mid_c_cin;
    logic             hi_c_slot, hi_c_cin;

    typedef struct packed {
        logic [HALF_W-1:0] n3;
        logic [HALF_W-1:0] n2;
        logic [HALF_W-1:0] n1;
        logic [HALF_W-1:0] n0;
    } cols_t;

    cols_t cols_d;

    nib_array_mul #(.W(HALF_W)) u_ll (
        .x_i(op_a[HALF_W-1:0]), .y_i(op_b[HALF_W-1:0]), .prod_o(pp_ll));
    nib_array_mul #(.W(HALF_W)) u_hl (
        .x_i(op_a[PP_W-1:HALF_W]), .y_i(op_b[HALF_W-1:0]), .prod_o(pp_hl));
    nib_array_mul #(.W(HALF_W)) u_lh (
        .x_i(op_a[HALF_W-1:0]), .y_i(op_b[PP_W-1:HALF_W]), .prod_o(pp_lh));
    nib_array_mul #(.W(HALF_W)) u_hh (
        .x_i(op_a[PP_W-1:HALF_W]), .y_i(op_b[PP_W-1:HALF_W]), .prod_o(pp_hh));

    add3_csa #(.W(HALF_W)) u_mid (
        .x_i   (pp_ll[PP_W-1:HALF_W]),
        .y_i   (pp_hl[HALF_W-1:0]),
        .z_i   (pp_lh[HALF_W-1:0]),
        .slot_i(1'b0),
        .ci_i  (1'b0),
        .res_o (mid_col)
    );

    // Column carry in {0,1,2} split into two weight-one lines
    assign mid_c_slot = mid_col[HALF_W] | mid_col[HALF_W+1];
    assign mid_c_cin  = mid_col[HALF_W+1];

    add3_csa #(.W(HALF_W)) u_hi (
        .x_i   (pp_hl[PP_W-1:HALF_W]),
        .y_i   (pp_lh[PP_W-1:HALF_W]),
        .z_i   (pp_hh[HALF_W-1:0]),
        .slot_i(mid_c_slot),
        .ci_i  (mid_c_cin),
        .res_o (hi_col)
    );

    assign hi_c_slot = hi_col[HALF_W] | hi_col[HALF_W+1];
    assign hi_c_cin  = hi_col[HALF_W+1];

    cpa_ripple #(.W(HALF_W)) u_top (
        .x_i  (pp_hh[PP_W-1:HALF_W]),
        .y_i  ({{(HALF_W-1){1'b0}}, hi_c_slot}),
        .ci_i (hi_c_cin),
        .sum_o(top_col)
    );

    always_comb begin
        cols_d    = '0;
        cols_d.n0 = pp_ll[HALF_W-1:0];
        cols_d.n1 = mid_col[HALF_W-1:0];
        cols_d.n2 = hi_col[HALF_W-1:0];
        cols_d.n3 = top_col[HALF_W-1:0];
    end

    assign prod = cols_d;

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R4
            mid_carry_range_chk: assert (mid_col[HALF_W+1:HALF_W] != 2'b11)
                else $error("middle column carry above two");
            // R5
            no_overflow_chk: assert (top_col[HALF_W] == 1'b0)
                else $error("top nibble overflow");
            // R1
            product_chk: assert (prod == (4*HALF_W)'(op_a) * (4*HALF_W)'(op_b))
                else $error("product mismatch");
        end
    end
endmodule

// File: tb/nibble_mult8_tb.sv
module nibble_mult8_tb;
    logic        clk = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] prod;

    int checks   = 0;
    int failures = 0;
    int dbl_carry_seen = 0;
    bit finished = 0;
    int unsigned exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    nibble_mult8 u_dut (.op_a(op_a), .op_b(op_b), .prod(prod));

    task automatic report(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s a=%0h b=%0h actual=%0h expected=%0h", tag, op_a, op_b, act, exp);
        end
    endtask

    // Drive after the falling edge; sample one ns after the next rising edge
    task automatic apply(input int unsigned a, input int unsigned b, input string tag);
        @(negedge clk);
        op_a = a[7:0];
        op_b = b[7:0];
        exp_q.push_back(a * b);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        report(tag_q.pop_front(), prod, exp_q.pop_front());
    endtask

    function automatic int unsigned mid_sum(input int unsigned a, input int unsigned b);
        int unsigned ll = (a % 16) * (b % 16);
        int unsigned hl = (a / 16) * (b % 16);
        int unsigned lh = (a % 16) * (b / 16);
        return ll / 16 + hl % 16 + lh % 16;
    endfunction

    initial begin
        // R8: no clock into the block; first value after inputs settle
        #1;
        report("R8 initial zero operands", prod, 0);
        apply(8'h0D, 8'h0B, "R2 13x11");
        apply(8'hD0, 8'hB0, "R2 high halves 13x11");
        apply(8'hFF, 8'hFF, "R5 max operands");
        apply(8'h00, 8'hA7, "R6 zero a");
        apply(8'h5C, 8'h00, "R6 zero b");
        apply(8'h01, 8'hE3, "R7 unit a");
        apply(8'h9B, 8'h01, "R7 unit b");
        apply(8'h37, 8'hC9, "R3 low nibble");
        report("R3 low nibble field", prod & 16'h000F, ((8'h7 * 8'h9) % 16));
        apply(8'hF0, 8'h0F, "R1 cross halves");
        // R8: operand change visible in the same period
        @(negedge clk);
        op_a = 8'h12;
        op_b = 8'h34;
        #3;
        report("R8 settles within period", prod, 16'h03A8);
        // R1 / R4 exhaustive sweep
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                if (mid_sum(ai, bi) >= 32) begin
                    dbl_carry_seen++;
                    apply(ai, bi, "R4 double middle carry");
                end else begin
                    apply(ai, bi, "R1 exhaustive");
                end
            end
        end
        checks++;
        if (dbl_carry_seen == 0) begin
            failures++;
            $display("FAIL R4 no double-carry pair met actual=0 expected>0");
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule